// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter with Byte FIFO

This block is a transmit-only synchronous serial engine. A host pushes bytes into a 16-entry FIFO with a single-cycle write strobe. Whenever the engine is idle and the FIFO holds data, it pulls the oldest byte into a shift register. It then sends the byte on `txd`, least significant bit first, with one bit per serial clock. The serial clock is either produced inside the block (eight low-going pulses per frame, idling high) or taken from the `sclk_in` pin. In the external case the input passes through a two-flop synchronizer and its edges are found with the system clock.

The engine looks at the FIFO when it starts the last bit of a frame. If another byte is waiting, the byte goes straight into the shift register and the next frame follows with no idle clock period. If the FIFO is empty, the transmit-end flag rises, the final bit completes, and `txd` keeps its last level. The host can pick a refill threshold of 0, 2, 4 or 8 entries. A low-occupancy flag rises whenever the FIFO holds no more than that many bytes, and it can raise an interrupt when enabled. A write to a full FIFO is dropped and recorded in a sticky overflow bit.

The control is a three-state machine. `ST_IDLE` is the state with no frame in progress; the serial clock is high. `ST_SHIFT` is the state in which bits are being sent. `ST_LAST` is the state in which the final bit of the final frame is on the line. The transitions are as follows. IDLE goes to SHIFT when the FIFO is not empty, and this transition loads the byte. SHIFT stays in SHIFT at the last-bit falling edge when the FIFO has a byte, which chains the next frame. SHIFT goes to LAST at that same edge when the FIFO is empty. LAST goes to IDLE on the following rising edge.

Top module: `syncser_tx`

## Requirements
- R1: The FIFO holds 16 bytes. A write while it holds 16 is discarded and sets `ovf`, which stays 1 until reset (reset value 0).
- R2: In internal-clock mode, a write to the FIFO of an idle engine starts a frame. The first falling edge of `sclk_out` is seen HALF+2 system cycles after the write is sampled (HALF defaults to 2).
- R3: Each frame carries 8 bits, bit 0 first through bit 7 last. `txd` changes only when the serial clock falls, and it is valid at the following rising edge.
- R4: In internal mode `sclk_out` gives exactly 8 low pulses per frame, with a period of 2*HALF system cycles. `sclk_out` rests at 1 whenever no frame is running, and it stays at 1 in external mode.
- R5: In external mode (`ext_mode`=1), `txd` moves to the next bit within 3 system cycles after each falling edge of `sclk_in`, and it does not change otherwise.
- R6: When a byte is in the FIFO at the falling edge that starts bit 7, the next frame follows with no gap. Consecutive rising serial clock edges stay 2*HALF cycles apart across the frame boundary.
- R7: `tend` resets to 1. It is set at the falling edge that starts bit 7 when the FIFO is empty, so it is 1 while bit 7 is on the line. Afterwards `txd` holds bit 7. Any accepted write clears `tend` in the next cycle.
- R8: The `trig_sel` codes are 0, 1, 2 and 3, and they select a threshold of 0, 2, 4 and 8 bytes. `empty_flag` resets to 1 and is set in every cycle in which the FIFO count is at or below the threshold. A one-cycle `empty_clr` clears it only if the count is above the threshold; otherwise the strobe has no effect.
- R9: `irq` is 1 exactly when `empty_flag` and `tie` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects the external serial clock, 0 selects the internal generator |
| trig_sel | input | 2 | Threshold code: 0, 1, 2 and 3 select 0, 2, 4 and 8 bytes |
| tie | input | 1 | Interrupt enable for the low-occupancy flag |
| wr_en | input | 1 | Write strobe that pushes `wr_data` into the FIFO |
| wr_data | input | 8 | Byte to transmit |
| empty_clr | input | 1 | Clear strobe for `empty_flag` |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock, idles high |
| txd | output | 1 | Serial data, LSB first |
| empty_flag | output | 1 | FIFO count at or below threshold |
| tend | output | 1 | Transmission ended with an empty FIFO |
| irq | output | 1 | Interrupt request |
| ovf | output | 1 | Sticky write-overflow status |

## Verification
The flags `ovf`, `tend` and `empty_flag` settle one system cycle after the edge that samples their cause. The bench drives on falling system edges and reads one or more falling edges later. In internal mode, the first serial clock fall is due HALF+2 cycles after the write edge. `txd` then changes at each serial fall and is read at the serial rise HALF cycles later, so a monitor triggered by the rising serial clock reads a settled value and also times the spacing between rises. In external mode the synchronizer adds up to 3 cycles between a falling `sclk_in` and the new `txd`. The bench therefore holds each `sclk_in` phase for 4 cycles and reads `txd` just before it raises the clock. The bench also fills the FIFO while the external clock is parked, which pins the count for every threshold code and fill level.

// File: rtl/syncser_tx_pkg.sv
`timescale 1ns/1ps
package syncser_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LAST  = 2'd2
    } tx_state_t;

    // threshold code decode: 0->0, 1->2, 2->4, 3->8 bytes (R8)
    function automatic int unsigned trig_level(input logic [1:0] code);
        int unsigned lvl;
        unique case (code)
            2'd0:    lvl = 0;
            2'd1:    lvl = 2;
            2'd2:    lvl = 4;
            default: lvl = 8;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/syncser_tx_fifo.sv
`timescale 1ns/1ps
module syncser_tx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_en,
    output logic [DATA_W-1:0]           rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        wr_acc,
    output logic                        ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              full, rd_acc;

    assign full    = (count == CW'(DEPTH));
    assign wr_acc  = wr_en && !full;
    assign rd_acc  = rd_en && (count != '0);
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_acc) wp <= wp + 1'b1;
            if (rd_acc) rp <= rp + 1'b1;
            unique case ({wr_acc, rd_acc})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && full) ovf <= 1'b1;
        end
    end

    assert_full_write_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (count == CW'(DEPTH)));
    assert_ovf_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/syncser_tx_tick.sv
`timescale 1ns/1ps
module syncser_tx_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_mode,
    input  logic sclk_in,
    output logic fall_evt,
    output logic rise_evt,
    output logic sclk_out
);
    localparam int CW = $clog2(HALF+1);

    logic [CW-1:0] cnt;
    logic          sclk_q;
    logic          s1, s2, s3;
    logic          int_evt;

    // two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= sclk_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // internal half-period divider, clock rests high when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run || ext_mode) begin
            cnt    <= '0;
            sclk_q <= 1'b1;
        end else if (cnt == CW'(HALF-1)) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign int_evt  = run && !ext_mode && (cnt == CW'(HALF-1));
    assign fall_evt = ext_mode ? (s3 & ~s2) : (int_evt & sclk_q);
    assign rise_evt = ext_mode ? (~s3 & s2) : (int_evt & ~sclk_q);
    assign sclk_out = sclk_q;

    assert_ext_clock_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && $past(ext_mode)) |-> sclk_out);

endmodule

// File: rtl/syncser_tx.sv
`timescale 1ns/1ps
module syncser_tx
    import syncser_tx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int HALF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic [1:0]        trig_sel,
    input  logic              tie,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              empty_clr,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              txd,
    output logic              empty_flag,
    output logic              tend,
    output logic              irq,
    output logic              ovf
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W-1);

    tx_state_t         state, state_nx;
    logic [CW-1:0]     fifo_cnt;
    logic [DATA_W-1:0] head, shreg;
    logic [BW-1:0]     bitcnt;
    logic              wr_acc, pop, have_data, fall_evt, rise_evt, msb_fall;

    assign have_data = (fifo_cnt != '0);
    assign msb_fall  = (state == ST_SHIFT) && fall_evt && (bitcnt == LAST_BIT);
    assign pop       = ((state == ST_IDLE) && have_data) || (msb_fall && have_data);

    syncser_tx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(head), .count(fifo_cnt), .wr_acc(wr_acc), .ovf(ovf)
    );

    syncser_tx_tick #(.HALF(HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .ext_mode(ext_mode),
        .sclk_in(sclk_in), .fall_evt(fall_evt), .rise_evt(rise_evt), .sclk_out(sclk_out)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (have_data) state_nx = ST_SHIFT;
            ST_SHIFT: if (msb_fall && !have_data) state_nx = ST_LAST;
            ST_LAST:  if (rise_evt) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            txd    <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (have_data) begin
                        shreg  <= head;
                        bitcnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (fall_evt) begin
                        txd <= shreg[0];
                        if (msb_fall && have_data) shreg <= head;
                        else                       shreg <= shreg >> 1;
                    end else if (rise_evt) begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tend       <= 1'b1;
            empty_flag <= 1'b1;
        end else begin
            if (wr_acc)                      tend <= 1'b0;
            else if (msb_fall && !have_data) tend <= 1'b1;
            if (int'(fifo_cnt) <= trig_level(trig_sel)) empty_flag <= 1'b1;
            else if (empty_clr)                          empty_flag <= 1'b0;
        end
    end

    assign irq = empty_flag & tie;

    assert_idle_clock_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> sclk_out);
    assert_tend_cleared_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !tend);
    assert_txd_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !$fell(sclk_out)) |-> $stable(txd));
    assert_flag_drop_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_flag) |-> $past(empty_clr));
    assert_chain_keeps_shifting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msb_fall && have_data) |=> (state == ST_SHIFT));

endmodule

// File: tb/syncser_tx_bench.sv
`timescale 1ns/1ps
module syncser_tx_bench;
    localparam int HALF = 2;
    localparam real TCLK = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       tie = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       empty_clr = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sclk_out, txd, empty_flag, tend, irq, ovf;

    int total = 0;
    int bad = 0;

    logic [7:0] exp_b [0:31];
    logic [7:0] rx_bytes [0:31];
    logic [7:0] rx_sh;
    int rx_nb, rx_n;
    bit mon_on = 1'b0;
    int rises, spacing_bad;
    realtime last_rise;

    always #2.5 clk = ~clk;

    syncser_tx #(.DEPTH(16), .DATA_W(8), .HALF(HALF)) u_syncser_tx (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .trig_sel(trig_sel), .tie(tie),
        .wr_en(wr_en), .wr_data(wr_data), .empty_clr(empty_clr), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .txd(txd), .empty_flag(empty_flag), .tend(tend),
        .irq(irq), .ovf(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rx_push(input logic b);
        rx_sh = {b, rx_sh[7:1]};
        rx_nb++;
        if (rx_nb == 8) begin
            rx_bytes[rx_n] = rx_sh;
            rx_n++;
            rx_nb = 0;
        end
    endtask

    task automatic rx_clear();
        rx_sh = 8'h00; rx_nb = 0; rx_n = 0;
        rises = 0; spacing_bad = 0;
    endtask

    // receiver for internal mode: samples on rising serial clock, times rises
    always @(posedge sclk_out) begin
        if (mon_on) begin
            if (rises > 0 && ($realtime - last_rise) != 2.0 * HALF * TCLK) spacing_bad++;
            last_rise = $realtime;
            rises++;
            rx_push(txd);
        end
    end

    task automatic do_reset(input logic ext, input logic [1:0] code, input logic ie);
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; ext_mode = ext; trig_sel = code; tie = ie;
        wr_en = 1'b0; empty_clr = 1'b0; sclk_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int lvl_of(input int code);
        return (code == 0) ? 0 : (code == 1) ? 2 : (code == 2) ? 4 : 8;
    endfunction

    // external mode: park clock, fill, check flags, then clock everything out
    task automatic run_fill(input int code, input int n, input logic ie);
        int ec, sent, lvl;
        do_reset(1'b1, 2'(code), ie);
        for (int i = 0; i < n; i++) begin
            exp_b[i] = 8'(i * 37 + n * 11 + code * 5 + 3);
            wr(exp_b[i]);
        end
        repeat (3) @(negedge clk);
        ec   = (n - 1 > 16) ? 16 : n - 1;
        sent = (n > 17) ? 17 : n;
        lvl  = lvl_of(code);
        chk("R1 overflow on write to full FIFO", int'(ovf), int'(n > 17));
        chk("R7 tend cleared by write", int'(tend), 0);
        chk("R4 sclk_out parked high in external mode", int'(sclk_out), 1);
        chk("R8 flag stays set without clear", int'(empty_flag), 1);
        @(negedge clk); empty_clr = 1'b1;
        @(negedge clk); empty_clr = 1'b0;
        chk("R8 flag after clear strobe", int'(empty_flag), int'(ec <= lvl));
        chk("R9 irq equals flag and enable", int'(irq), int'((ec <= lvl) && ie));
        rx_clear();
        for (int k = 0; k < sent * 8; k++) begin
            sclk_in = 1'b0;
            repeat (4) @(negedge clk);
            rx_push(txd);
            if (k == sent * 8 - 2) chk("R7 tend low before last bit 7", int'(tend), 0);
            if (k == sent * 8 - 1) chk("R7 tend set during last bit 7", int'(tend), 1);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk("R5 frame count in external mode", rx_n, sent);
        for (int i = 0; i < sent; i++)
            chk("R5 R3 byte order and bit order", int'(rx_bytes[i]), int'(exp_b[i]));
        chk("R7 txd holds bit 7 after end", int'(txd), int'(exp_b[sent-1][7]));
        chk("R8 flag set when drained", int'(empty_flag), 1);
        chk("R1 overflow sticky", int'(ovf), int'(n > 17));
    endtask

    // internal mode burst: latency, pulses, spacing, data
    task automatic run_burst(input int n);
        int first_low;
        do_reset(1'b0, 2'd3, 1'b1);
        rx_clear();
        mon_on = 1'b1;
        for (int i = 0; i < n; i++) exp_b[i] = 8'(8'hA5 ^ (i * 53 + n));
        @(negedge clk); wr_en = 1'b1; wr_data = exp_b[0];
        @(negedge clk); wr_en = 1'b0;
        first_low = 0;
        for (int k = 2; k <= 8; k++) begin
            @(negedge clk);
            if (!sclk_out && first_low == 0) first_low = k;
        end
        chk("R2 first serial fall after write", first_low, HALF + 2);
        for (int i = 1; i < n; i++) wr(exp_b[i]);
        repeat (n * 8 * 2 * HALF + 20) @(negedge clk);
        chk("R4 eight pulses per frame", rises, 8 * n);
        chk("R6 R4 constant spacing across frames", spacing_bad, 0);
        chk("R3 frame count", rx_n, n);
        for (int i = 0; i < n; i++)
            chk("R3 LSB-first byte content", int'(rx_bytes[i]), int'(exp_b[i]));
        chk("R4 sclk_out rests high", int'(sclk_out), 1);
        chk("R7 tend after burst", int'(tend), 1);
        chk("R7 txd holds last bit 7", int'(txd), int'(exp_b[n-1][7]));
        mon_on = 1'b0;
    endtask

    initial begin
        #(TCLK * 190000.0);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(1'b0, 2'd1, 1'b1);
        chk("R4 reset sclk_out", int'(sclk_out), 1);
        chk("R3 reset txd", int'(txd), 1);
        chk("R7 reset tend", int'(tend), 1);
        chk("R8 reset flag", int'(empty_flag), 1);
        chk("R1 reset ovf", int'(ovf), 0);
        chk("R9 reset irq", int'(irq), 1);

        run_burst(1);
        run_burst(2);
        run_burst(5);
        run_burst(10);

        for (int code = 0; code < 4; code++)
            for (int n = 1; n <= 18; n++)
                run_fill(code, n, 1'(n));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule